// File: doc/BRIEF.md
# Triggered Performance Counter Unit

This unit watches a bus of single-cycle event pulses and counts them in four 32-bit counters. Each counter has its own selector field that picks one event line. Two control registers hold the selectors and a small set of mode bits. A simple synchronous register port writes those registers and reads them back, along with a read-only user copy of control register 0 and the four counters.

In trigger mode only counter 1 runs. Counters 2 to 4 wait until counter 1 turns negative, which means its top bit is set, or until another enabled condition occurs. At that point the hardware clears the trigger bit by itself, so counters 2 to 4 record only what happens after counter 1 has crossed its threshold. Negative counters can be enabled as conditions. An enabled condition can freeze every counter, can raise a level interrupt request, or can do both.

Top module: `evmon_unit`

## Requirements
- R1: After a synchronous active-low reset, both control registers, the user copy and all four counters read zero, and `irq_o` is low.
- R2: On each rising edge a counter adds exactly 1 when its selected line `evt_in[code]` is high and the counter is neither held nor frozen. A selector code equal to or above `NUM_EVT` counts nothing, even when every event line is high.
- R3: While the trigger bit (control 0 bit 27) is set, counter 1 keeps counting and counters 2 to 4 keep their values.
- R4: When the trigger bit is set and either counter 1 is negative or an enabled condition is true, the trigger bit reads 0 after the next edge. Counters 2 to 4 count from the edge after that.
- R5: An enabled condition is true when bit 29 is set and counter 1 bit 31 is 1, or when bit 28 is set and bit 31 of any of counters 2 to 4 is 1. While freeze (bit 31) is set and a condition is true, no counter changes.
- R6: While interrupt enable (bit 30) is set, a true condition drives `irq_o` high from the next edge. With freeze clear, the counters keep counting.
- R7: Once raised, `irq_o` stays high until bit 30 is cleared. It drops on the second edge after the write that clears the bit.
- R8: Control 0 keeps bits 31..27 and bits 12..0 and reads zero elsewhere. Counter 1's selector is in bits 12..6 and counter 2's is in bits 5..0. Control 1 has counter 3's selector in bits 31..27 and counter 4's in bits 26..22, and reads zero in bits 21..0.
- R9: Address 2 returns control 0. Writes to address 2 change nothing.
- R10: Register addresses are 0 for control 0, 1 for control 1, and 4 to 7 for counters 1 to 4. A write to a counter loads the written value at that edge, with no increment added in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | NUM_EVT | Per-cycle event pulses |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe, applied at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| irq_o | output | 1 | Level interrupt request |

## Verification
Reads are combinational, so a written register or a counter shows its new value right after the edge that captured the write or the event. The trigger bit drops one edge after a release cause appears, and counters 2 to 4 move from the edge after that. A freeze takes effect on the edge after the condition appears, and `irq_o` rises one edge after the condition. The bench drives its inputs just after each rising edge and counts edges explicitly. Every expected counter value is worked out from that edge count, and the bench samples between edges.

// File: rtl/evmon_pkg.sv
// evmon_pkg: shared constants for the event monitor.
// Holds the register addresses, the control bit positions and the writable masks.
// Assumes 32-bit counters and a 3-bit register address.
package evmon_pkg;
    localparam int CW      = 32;
    localparam int NCTR    = 4;
    localparam int AW      = 3;
    localparam int SELW    = 7;

    localparam logic [AW-1:0] A_CTL0  = 3'd0;
    localparam logic [AW-1:0] A_CTL1  = 3'd1;
    localparam logic [AW-1:0] A_UCTL0 = 3'd2;
    localparam logic [AW-1:0] A_CNT0  = 3'd4;

    localparam int B_FRZ  = 31;
    localparam int B_IRQE = 30;
    localparam int B_C1NE = 29;
    localparam int B_CXNE = 28;
    localparam int B_TRIG = 27;

    localparam int S1_LSB = 6;
    localparam int S1_W   = 7;
    localparam int S2_LSB = 0;
    localparam int S2_W   = 6;
    localparam int S3_LSB = 27;
    localparam int S4_LSB = 22;
    localparam int SX_W   = 5;

    localparam logic [CW-1:0] CTL0_MASK = 32'hF800_1FFF;
    localparam logic [CW-1:0] CTL1_MASK = 32'hFFC0_0000;
endpackage

// File: rtl/evmon_evsel.sv
// evmon_evsel: picks one event line by code.
// A code at or above NUM_EVT selects nothing, so the output is 0.
module evmon_evsel #(
    parameter int NUM_EVT = 16,
    parameter int SW      = 7
) (
    input  logic [SW-1:0]      code,
    input  logic [NUM_EVT-1:0] evt,
    output logic               hit
);
    // Compare the code with every wired line and OR the matches.
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (32'(code) == i) hit = hit | evt[i];
        end
    end
endmodule

// File: rtl/evmon_ctr.sv
// evmon_ctr: one event counter with a software load.
// The load has priority over the increment, and the increment adds at most 1.
module evmon_ctr #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [CW-1:0] ld_val,
    input  logic          inc,
    output logic [CW-1:0] q
);
    // Count register: reset, load, increment or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (ld)  q <= ld_val;
        else if (inc) q <= q + CW'(1);
    end
endmodule

// File: rtl/evmon_ctl.sv
// evmon_ctl: the control registers, condition detection, trigger release,
// freeze and the interrupt level.
// Assumes neg1 and negx come straight from the counters' top bits.
module evmon_ctl
    import evmon_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctl0,
    input  logic          wr_ctl1,
    input  logic [CW-1:0] wdata,
    input  logic          neg1,
    input  logic          negx,
    output logic [CW-1:0] ctl0_q,
    output logic [CW-1:0] ctl1_q,
    output logic          hold_x,
    output logic          frozen,
    output logic          irq_q
);
    logic cond;
    logic release_x;

    // An enabled condition: a negative counter whose enable bit is set.
    always_comb begin
        cond = (ctl0_q[B_C1NE] & neg1) | (ctl0_q[B_CXNE] & negx);
    end

    // Hold, freeze and trigger release decisions.
    always_comb begin
        hold_x    = ctl0_q[B_TRIG];
        frozen    = ctl0_q[B_FRZ] & cond;
        release_x = ctl0_q[B_TRIG] & (neg1 | cond);
    end

    // Control 0: a software write wins over the hardware clear of the trigger bit.
    always_ff @(posedge clk) begin
        if (!rst_n)         ctl0_q <= '0;
        else if (wr_ctl0)   ctl0_q <= wdata & CTL0_MASK;
        else if (release_x) ctl0_q[B_TRIG] <= 1'b0;
    end

    // Control 1: the selectors for counters 3 and 4.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctl1_q <= '0;
        else if (wr_ctl1) ctl1_q <= wdata & CTL1_MASK;
    end

    // Interrupt level: set by a condition while enabled, cleared when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                  irq_q <= 1'b0;
        else if (!ctl0_q[B_IRQE])    irq_q <= 1'b0;
        else if (cond)               irq_q <= 1'b1;
    end
endmodule

// File: rtl/evmon_unit.sv
// evmon_unit: top of the four-counter event monitor.
// Decodes the register port, routes the selectors to the event muxes,
// and gates each counter's increment with the hold and freeze decisions.
// Assumes reads are combinational and writes take effect at the rising edge.
module evmon_unit
    import evmon_pkg::*;
#(
    parameter int NUM_EVT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic [2:0]         reg_addr,
    input  logic               reg_wr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq_o
);
    logic [CW-1:0]             ctl0_q;
    logic [CW-1:0]             ctl1_q;
    logic [NCTR-1:0][CW-1:0]   cnt_q;
    logic [NCTR-1:0][SELW-1:0] sel;
    logic [NCTR-1:0]           hit;
    logic                      hold_x;
    logic                      frozen;
    logic                      negx;

    // Route each counter's selector field, zero-extended to a common width.
    always_comb begin
        sel[0] = SELW'(ctl0_q[S1_LSB +: S1_W]);
        sel[1] = SELW'(ctl0_q[S2_LSB +: S2_W]);
        sel[2] = SELW'(ctl1_q[S3_LSB +: SX_W]);
        sel[3] = SELW'(ctl1_q[S4_LSB +: SX_W]);
    end

    // Negative flag across counters 2 to 4.
    always_comb begin
        negx = 1'b0;
        for (int k = 1; k < NCTR; k++) negx = negx | cnt_q[k][CW-1];
    end

    evmon_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctl0 (reg_wr && reg_addr == A_CTL0),
        .wr_ctl1 (reg_wr && reg_addr == A_CTL1),
        .wdata   (reg_wdata),
        .neg1    (cnt_q[0][CW-1]),
        .negx    (negx),
        .ctl0_q  (ctl0_q),
        .ctl1_q  (ctl1_q),
        .hold_x  (hold_x),
        .frozen  (frozen),
        .irq_q   (irq_o)
    );

    for (genvar k = 0; k < NCTR; k++) begin : g_ctr
        logic ld;
        logic inc;

        evmon_evsel #(.NUM_EVT(NUM_EVT), .SW(SELW)) u_sel (
            .code (sel[k]),
            .evt  (evt_in),
            .hit  (hit[k])
        );

        // Load strobe and gated increment for this counter.
        always_comb begin
            ld  = reg_wr && (reg_addr == A_CNT0 + AW'(k));
            inc = hit[k] && !frozen && !((k != 0) && hold_x);
        end

        evmon_ctr #(.CW(CW)) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (ld),
            .ld_val (reg_wdata),
            .inc    (inc),
            .q      (cnt_q[k])
        );
    end

    // Read mux: control registers, the user copy, the counters, otherwise zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTL0, A_UCTL0: reg_rdata = ctl0_q;
            A_CTL1:          reg_rdata = ctl1_q;
            3'd4:            reg_rdata = cnt_q[0];
            3'd5:            reg_rdata = cnt_q[1];
            3'd6:            reg_rdata = cnt_q[2];
            3'd7:            reg_rdata = cnt_q[3];
            default:         reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/evmon_chk.sv
// evmon_chk: property checker for evmon_unit, attached through bind.
// Watches the control registers, the counters and the interrupt over time.
module evmon_chk
    import evmon_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [2:0]              reg_addr,
    input  logic [CW-1:0]           ctl0,
    input  logic [CW-1:0]           ctl1,
    input  logic [NCTR-1:0][CW-1:0] cnt,
    input  logic                    irq
);
    logic negx_c;
    logic cond_c;

    // Condition rebuilt from the control bits and the counter signs.
    always_comb begin
        negx_c = cnt[1][CW-1] | cnt[2][CW-1] | cnt[3][CW-1];
        cond_c = (ctl0[B_C1NE] & cnt[0][CW-1]) | (ctl0[B_CXNE] & negx_c);
    end

    for (genvar k = 0; k < NCTR; k++) begin : g_k
        AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            !(reg_wr && reg_addr == A_CNT0 + 3'(k)) |=> (cnt[k] - $past(cnt[k])) <= CW'(1)); // R2
        if (k != 0) begin : g_hold
            AST_HOLD_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
                ctl0[B_TRIG] && !(reg_wr && reg_addr == A_CNT0 + 3'(k)) |=> $stable(cnt[k])); // R3
        end
    end

    AST_TRIG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ctl0[B_TRIG] && cnt[0][CW-1] && !(reg_wr && reg_addr == A_CTL0) |=> !ctl0[B_TRIG]); // R4

    AST_FREEZE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        ctl0[B_FRZ] && cond_c && !reg_wr |=> $stable(cnt)); // R5

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl0[B_IRQE] && cond_c |=> irq); // R6

    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl0[B_IRQE] |=> !irq); // R7

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl0 & ~CTL0_MASK) == '0) && ((ctl1 & ~CTL1_MASK) == '0)); // R8
endmodule

bind evmon_unit evmon_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .ctl0     (ctl0_q),
    .ctl1     (ctl1_q),
    .cnt      (cnt_q),
    .irq      (irq_o)
);

// File: tb/evmon_unit_tb.sv
module evmon_unit_tb;
    localparam int NE = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NE-1:0] evt_in;
    logic [2:0]    reg_addr;
    logic          reg_wr;
    logic [31:0]   reg_wdata;
    logic [31:0]   reg_rdata;
    logic          irq_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    evmon_unit #(.NUM_EVT(NE)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rdchk(input string req, input logic [2:0] a, input logic [31:0] exp);
        reg_addr = a; #1;
        check(req, reg_rdata, exp);
    endtask

    function automatic logic [31:0] c0(input bit frz, input bit irqe, input bit c1ne,
                                       input bit cxne, input bit trig,
                                       input logic [6:0] s1, input logic [5:0] s2);
        return {frz, irqe, c1ne, cxne, trig, 14'b0, s1, s2};
    endfunction

    function automatic logic [31:0] c1(input logic [4:0] s3, input logic [4:0] s4);
        return {s3, s4, 22'b0};
    endfunction

    task automatic clear_all();
        wr(3'd0, 32'h0); wr(3'd1, 32'h0);
        for (int k = 0; k < 4; k++) wr(3'(4 + k), 32'h0);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; evt_in = '0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        rdchk("R1", 3'd0, 0); rdchk("R1", 3'd1, 0); rdchk("R1", 3'd2, 0);
        rdchk("R1", 3'd4, 0); rdchk("R1", 3'd5, 0); rdchk("R1", 3'd6, 0);
        rdchk("R1", 3'd7, 0);
        check("R1 irq", 32'(irq_o), 0);
        tick(1);

        // R8 field masks, R9 user copy and ignored writes
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd1, 32'hFFFF_FFFF);
        rdchk("R8 ctl0", 3'd0, 32'hF800_1FFF);
        rdchk("R8 ctl1", 3'd1, 32'hFFC0_0000);
        rdchk("R9 copy", 3'd2, 32'hF800_1FFF);
        wr(3'd2, 32'h0);
        rdchk("R9 write ignored", 3'd0, 32'hF800_1FFF);
        rdchk("R9 copy after write", 3'd2, 32'hF800_1FFF);
        clear_all();

        // R2 sweep over selector codes, including codes with no event wired
        for (int c = 0; c < 21; c++) begin
            logic [31:0] exp;
            wr(3'd0, c0(0, 0, 0, 0, 0, 7'(c), 6'(c)));
            wr(3'd1, c1(5'(c), 5'(c)));
            for (int k = 0; k < 4; k++) wr(3'(4 + k), 32'h0);
            for (int t = 0; t < 5; t++) begin
                if (((t + c) & 1) == 1) evt_in = '1;
                else                    evt_in = ~(NE'(1) << c);
                tick(1);
            end
            evt_in = '0;
            exp = (c < NE) ? (((c & 1) == 0) ? 32'd2 : 32'd3) : 32'd0;
            for (int k = 0; k < 4; k++) rdchk($sformatf("R2 code %0d ctr %0d", c, k + 1), 3'(4 + k), exp);
            tick(1);
        end
        clear_all();

        // R10 counter write wins over a same-cycle event
        evt_in = NE'(1);
        wr(3'd4, 32'd100);
        rdchk("R10 load", 3'd4, 32'd100);
        tick(1);
        rdchk("R10 count after load", 3'd4, 32'd101);
        evt_in = '0;
        clear_all();

        // R3/R4 trigger released by counter 1 turning negative
        wr(3'd4, 32'h7FFF_FFFD);
        wr(3'd0, c0(0, 0, 0, 0, 1, 7'd0, 6'd0));
        evt_in = NE'(1);
        tick(3);
        evt_in = '0;
        rdchk("R3 trig still set", 3'd0, c0(0, 0, 0, 0, 1, 7'd0, 6'd0));
        rdchk("R3 ctr1 runs", 3'd4, 32'h8000_0000);
        rdchk("R3 ctr2 held", 3'd5, 0);
        tick(1);
        rdchk("R4 trig cleared", 3'd0, 0);
        evt_in = NE'(1);
        tick(3);
        evt_in = '0;
        rdchk("R4 ctr1", 3'd4, 32'h8000_0003);
        rdchk("R4 ctr2", 3'd5, 3); rdchk("R4 ctr3", 3'd6, 3); rdchk("R4 ctr4", 3'd7, 3);
        tick(1);
        clear_all();

        // R4 trigger released by an enabled condition on counter 2
        wr(3'd5, 32'h8000_0000);
        wr(3'd0, c0(0, 0, 0, 1, 1, 7'd0, 6'd0));
        rdchk("R4 cond trig set", 3'd0, c0(0, 0, 0, 1, 1, 7'd0, 6'd0));
        tick(1);
        rdchk("R4 cond trig cleared", 3'd0, c0(0, 0, 0, 1, 0, 7'd0, 6'd0));
        clear_all();

        // R5 trigger then freeze, R6 interrupt with freeze
        wr(3'd4, 32'h7FFF_FFFF);
        wr(3'd5, 32'h7FFF_FFFE);
        wr(3'd0, c0(1, 1, 0, 1, 1, 7'd0, 6'd0));
        evt_in = NE'(1);
        tick(8);
        rdchk("R5 ctr1", 3'd4, 32'h8000_0003);
        rdchk("R5 ctr2", 3'd5, 32'h8000_0000);
        rdchk("R5 ctr3", 3'd6, 2);
        rdchk("R5 ctr4", 3'd7, 2);
        check("R6 irq with freeze", 32'(irq_o), 1);
        evt_in = '0;
        wr(3'd0, c0(0, 0, 0, 1, 0, 7'd0, 6'd0));
        check("R7 irq held one edge", 32'(irq_o), 1);
        tick(1);
        check("R7 irq dropped", 32'(irq_o), 0);
        clear_all();

        // R6 interrupt without freeze, R7 level hold and clear
        wr(3'd4, 32'h7FFF_FFFF);
        wr(3'd0, c0(0, 1, 1, 0, 0, 7'd0, 6'd0));
        evt_in = NE'(1);
        tick(1);
        check("R6 irq not yet", 32'(irq_o), 0);
        tick(3);
        evt_in = '0;
        check("R6 irq raised", 32'(irq_o), 1);
        rdchk("R6 ctr1 keeps counting", 3'd4, 32'h8000_0003);
        rdchk("R6 ctr2 keeps counting", 3'd5, 4);
        wr(3'd4, 32'h0);
        tick(3);
        check("R7 irq level held", 32'(irq_o), 1);
        wr(3'd0, 32'h0);
        tick(1);
        check("R7 irq cleared", 32'(irq_o), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule